// File: doc/BRIEF.md
# Shared Memory Slot Arbiter

This block owns a 128-word by 32-bit data memory and shares it among four agents: a filter engine, a real-time monitor port, a compute engine and a host processor with an 8-bit data path. A free-running slot counter with a period of four cycles gives fixed turns to the filter, the monitor and the host. The fourth turn belongs to the compute engine. The compute engine also gets the memory in a reserved turn that its owner does not use. The schedule is fixed, so no two agents ever drive the memory in the same cycle.

The host accesses full words through holding registers. It writes bytes 0 to 3 into a write holding register, lowest byte first. The write of byte 3 commits the whole word in the next host turn. A read of byte 0 fetches the whole word into a read holding register in the host turn. Bytes 1 to 3 are then returned from that register at once. While a host transfer waits for its turn, the host ready signal is held low, which gives the host wait states. The filter writes converter results into the low words. Words 0 to 7 carry, in order: phase A current, phase A voltage, phase B current, phase B voltage, two spare words, temperature and battery voltage.

Top module: `shmem_slot_arbiter`

## Requirements
- R1: `cur_slot` resets to 0 and then steps 0, 1, 2, 3, 0, … once per clock. Slot 0 is the filter turn, slot 1 the monitor turn, slot 2 the host turn and slot 3 the compute-engine turn.
- R2: `filt_gnt` is high only in slot 0 with `filt_req` high, and `mon_gnt` is high only in slot 1 with `mon_req` high. At most one grant is high in any cycle.
- R3: `ce_gnt` is high when `ce_req` is high in slot 3, and in slot 0, 1 or 2 when that slot's owner is idle. It is never high in a slot whose owner is active. The host counts as active while a transfer is pending.
- R4: A granted read sets `rd_vld` at the next clock edge, with `rd_data` holding the word and `rd_who` holding the reader's code: 0 filter, 1 monitor, 2 host, 3 compute engine. A granted write does not set `rd_vld`.
- R5: A host write (`host_we`=1) of byte select 0, 1 or 2 loads `host_wdata` into bits [8*sel+7:8*sel] of the write holding register with no wait. `host_ready` stays high.
- R6: A host write of byte select 3 commits the full holding word to `host_addr` at the first host-slot edge after the strobe edge. `host_ready` is low from the strobe edge until that commit edge.
- R7: A host read of byte select 0 fetches the word at the first host-slot edge after the strobe. The word is latched one edge later, and at that edge `host_rdata` shows bits [7:0] and `host_ready` returns high.
- R8: A host read of byte select 1, 2 or 3 returns the matching byte of the read holding register at the next edge with no wait. Memory writes made since the byte-0 read do not affect it.
- R9: After reset `host_ready` is 1, `rd_vld` is 0 and `host_rdata` is 0.
- R10: Every one of the 128 words keeps the last value written to it and returns that value on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_req | input | 1 | Filter access request |
| filt_we | input | 1 | Filter write (1) or read (0) |
| filt_addr | input | 7 | Filter word address |
| filt_wdata | input | 32 | Filter write word |
| filt_gnt | output | 1 | Filter granted this cycle |
| mon_req | input | 1 | Monitor read request |
| mon_addr | input | 7 | Monitor word address |
| mon_gnt | output | 1 | Monitor granted this cycle |
| ce_req | input | 1 | Compute-engine access request |
| ce_we | input | 1 | Compute-engine write (1) or read (0) |
| ce_addr | input | 7 | Compute-engine word address |
| ce_wdata | input | 32 | Compute-engine write word |
| ce_gnt | output | 1 | Compute engine granted this cycle |
| host_stb | input | 1 | Host access strobe, one cycle, only while ready |
| host_we | input | 1 | Host byte write (1) or read (0) |
| host_addr | input | 7 | Host word address |
| host_bsel | input | 2 | Host byte select within the word |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_ready | output | 1 | Low while a host transfer waits for its slot |
| rd_data | output | 32 | Read word from memory |
| rd_vld | output | 1 | rd_data holds a fresh read |
| rd_who | output | 2 | Code of the agent that made the read |
| cur_slot | output | 2 | Current slot number |

## Verification
A filter sweep writes a distinct product-based word to every address, and a monitor sweep reads them all back. This separates correct addressing and persistence from aliasing or lost writes. All requests are then held high together over one full slot period to check that each reserved owner wins its own slot and the compute engine wins only the free ones. Host byte writes and byte-0 reads are started in each of the four slot phases, and the wait counts are compared with the slot distance computed in the bench, which exposes off-by-one errors in the turn logic. Before the host reads bytes 1 to 3, the word is overwritten in memory, so the bench can tell holding-register reads from direct memory reads.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  typedef enum logic [1:0] {
    AG_FILT = 2'd0,
    AG_MON  = 2'd1,
    AG_HOST = 2'd2,
    AG_CE   = 2'd3
  } agent_t;

  localparam int unsigned SLOT_COUNT = 4;

  // converter result words written by the filter
  localparam logic [6:0] W_I_PHA    = 7'h00;
  localparam logic [6:0] W_V_PHA    = 7'h01;
  localparam logic [6:0] W_I_PHB    = 7'h02;
  localparam logic [6:0] W_V_PHB    = 7'h03;
  localparam logic [6:0] W_SPARE0   = 7'h04;
  localparam logic [6:0] W_SPARE1   = 7'h05;
  localparam logic [6:0] W_TEMP     = 7'h06;
  localparam logic [6:0] W_BATT     = 7'h07;
endpackage

// File: rtl/slot_seq.sv
module slot_seq
  import shmem_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output agent_t slot
);
  logic [1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= 2'd0;
    else     cnt_q <= cnt_q + 2'd1;
  end

  assign slot = agent_t'(cnt_q);

  assert_slot_step_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt_q == $past(cnt_q) + 2'd1);
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/host_bridge.sv
module host_bridge #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NBYTES = DATA_W / BYTE_W,
  localparam int unsigned BSEL_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BSEL_W-1:0] bsel,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] rbyte,
  output logic              ready,
  input  logic              host_slot,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pend,
  output logic              op_fire,
  output logic              op_we,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata
);
  localparam logic [BSEL_W-1:0] LAST_B = BSEL_W'(NBYTES - 1);

  logic [DATA_W-1:0] wr_hold, rd_hold;
  logic              pend_we, fetch_q;
  logic [ADDR_W-1:0] pend_addr;
  logic              take;

  assign take     = stb && ready;
  assign op_fire  = pend && host_slot;
  assign op_we    = pend_we;
  assign op_addr  = pend_addr;
  assign op_wdata = wr_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_hold   <= '0;
      rd_hold   <= '0;
      pend      <= 1'b0;
      pend_we   <= 1'b0;
      pend_addr <= '0;
      fetch_q   <= 1'b0;
      ready     <= 1'b1;
      rbyte     <= '0;
    end else begin
      if (take) begin
        if (we) begin
          wr_hold[bsel*BYTE_W +: BYTE_W] <= wbyte;
          if (bsel == LAST_B) begin
            pend      <= 1'b1;
            pend_we   <= 1'b1;
            pend_addr <= addr;
            ready     <= 1'b0;
          end
        end else if (bsel == '0) begin
          pend      <= 1'b1;
          pend_we   <= 1'b0;
          pend_addr <= addr;
          ready     <= 1'b0;
        end else begin
          rbyte <= rd_hold[bsel*BYTE_W +: BYTE_W];
        end
      end
      if (op_fire) begin
        pend <= 1'b0;
        if (pend_we) ready   <= 1'b1;
        else         fetch_q <= 1'b1;
      end
      if (fetch_q) begin
        rd_hold <= mem_rdata;
        rbyte   <= mem_rdata[BYTE_W-1:0];
        ready   <= 1'b1;
        fetch_q <= 1'b0;
      end
    end
  end

  assert_wait_while_pending_R6: assert property (@(posedge clk) disable iff (rst)
    pend |-> !ready);
  assert_fetch_then_ready_R7: assert property (@(posedge clk) disable iff (rst)
    fetch_q |=> ready && !fetch_q);
  assert_low_bytes_no_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (take && we && bsel != LAST_B) |=> ready);
endmodule

// File: rtl/shmem_slot_arbiter.sv
module shmem_slot_arbiter
  import shmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NBYTES = DATA_W / BYTE_W,
  localparam int unsigned BSEL_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              filt_req,
  input  logic              filt_we,
  input  logic [ADDR_W-1:0] filt_addr,
  input  logic [DATA_W-1:0] filt_wdata,
  output logic              filt_gnt,
  input  logic              mon_req,
  input  logic [ADDR_W-1:0] mon_addr,
  output logic              mon_gnt,
  input  logic              ce_req,
  input  logic              ce_we,
  input  logic [ADDR_W-1:0] ce_addr,
  input  logic [DATA_W-1:0] ce_wdata,
  output logic              ce_gnt,
  input  logic              host_stb,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BSEL_W-1:0] host_bsel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic [1:0]        rd_who,
  output logic [1:0]        cur_slot
);
  agent_t            slot;
  logic              host_pend, host_fire, host_op_we;
  logic [ADDR_W-1:0] host_op_addr;
  logic [DATA_W-1:0] host_op_wdata;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  agent_t            owner;

  slot_seq u_seq (
    .clk  (clk),
    .rst  (rst),
    .slot (slot)
  );

  host_bridge #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
  ) u_bridge (
    .clk       (clk),
    .rst       (rst),
    .stb       (host_stb),
    .we        (host_we),
    .addr      (host_addr),
    .bsel      (host_bsel),
    .wbyte     (host_wdata),
    .rbyte     (host_rdata),
    .ready     (host_ready),
    .host_slot (slot == AG_HOST),
    .mem_rdata (rd_data),
    .pend      (host_pend),
    .op_fire   (host_fire),
    .op_we     (host_op_we),
    .op_addr   (host_op_addr),
    .op_wdata  (host_op_wdata)
  );

  // slot owner has priority; the compute engine fills idle turns
  always_comb begin
    filt_gnt = 1'b0;
    mon_gnt  = 1'b0;
    ce_gnt   = 1'b0;
    owner    = AG_CE;
    unique case (slot)
      AG_FILT: if (filt_req) begin filt_gnt = 1'b1; owner = AG_FILT; end
               else ce_gnt = ce_req;
      AG_MON:  if (mon_req) begin mon_gnt = 1'b1; owner = AG_MON; end
               else ce_gnt = ce_req;
      AG_HOST: if (host_pend) owner = AG_HOST;
               else ce_gnt = ce_req;
      default: ce_gnt = ce_req;
    endcase
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ce_addr;
    mem_wdata = ce_wdata;
    unique case (owner)
      AG_FILT: begin mem_en = 1'b1; mem_we = filt_we; mem_addr = filt_addr;
                     mem_wdata = filt_wdata; end
      AG_MON:  begin mem_en = 1'b1; mem_addr = mon_addr; end
      AG_HOST: begin mem_en = host_fire; mem_we = host_op_we;
                     mem_addr = host_op_addr; mem_wdata = host_op_wdata; end
      default: begin mem_en = ce_gnt; mem_we = ce_we; end
    endcase
  end

  word_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk   (clk),
    .en    (mem_en),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      rd_who <= 2'd0;
    end else begin
      rd_vld <= mem_en && !mem_we;
      rd_who <= owner;
    end
  end

  assign cur_slot = slot;

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({filt_gnt, mon_gnt, ce_gnt, host_fire}));
  assert_filt_slot_R2: assert property (@(posedge clk) disable iff (rst)
    filt_gnt |-> cur_slot == 2'd0);
  assert_mon_slot_R2: assert property (@(posedge clk) disable iff (rst)
    mon_gnt |-> cur_slot == 2'd1);
  assert_ce_yields_R3: assert property (@(posedge clk) disable iff (rst)
    ce_gnt |-> !((cur_slot == 2'd0 && filt_req) || (cur_slot == 2'd1 && mon_req)
                 || (cur_slot == 2'd2 && host_pend)));
  assert_host_in_own_slot_R6: assert property (@(posedge clk) disable iff (rst)
    host_fire |-> cur_slot == 2'd2);
  assert_read_flag_R4: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(mem_en && !mem_we));
endmodule

// File: tb/shmem_slot_arbiter_tb.sv
module shmem_slot_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        filt_req = 0, filt_we = 0, mon_req = 0, ce_req = 0, ce_we = 0;
  logic [6:0]  filt_addr = 0, mon_addr = 0, ce_addr = 0, host_addr = 0;
  logic [31:0] filt_wdata = 0, ce_wdata = 0;
  logic        host_stb = 0, host_we = 0;
  logic [1:0]  host_bsel = 0;
  logic [7:0]  host_wdata = 0;
  logic        filt_gnt, mon_gnt, ce_gnt, host_ready, rd_vld;
  logic [7:0]  host_rdata;
  logic [31:0] rd_data;
  logic [1:0]  rd_who, cur_slot;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shmem_slot_arbiter u_dut (
    .clk(clk), .rst(rst),
    .filt_req(filt_req), .filt_we(filt_we), .filt_addr(filt_addr),
    .filt_wdata(filt_wdata), .filt_gnt(filt_gnt),
    .mon_req(mon_req), .mon_addr(mon_addr), .mon_gnt(mon_gnt),
    .ce_req(ce_req), .ce_we(ce_we), .ce_addr(ce_addr), .ce_wdata(ce_wdata),
    .ce_gnt(ce_gnt),
    .host_stb(host_stb), .host_we(host_we), .host_addr(host_addr),
    .host_bsel(host_bsel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready),
    .rd_data(rd_data), .rd_vld(rd_vld), .rd_who(rd_who), .cur_slot(cur_slot)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    return 32'h9E37_79B9 * (a + 1) ^ 32'h0000_5A5A;
  endfunction

  task automatic to_slot(input int s);
    @(negedge clk);
    while (cur_slot != 2'(s)) @(negedge clk);
  endtask

  task automatic filt_wr(input int a, input logic [31:0] d);
    to_slot(0);
    filt_req = 1; filt_we = 1; filt_addr = 7'(a); filt_wdata = d;
    #0.5;
    if (!filt_gnt) chk(0, "R2 filt_gnt", filt_gnt, 1);
    @(negedge clk);
    filt_req = 0; filt_we = 0;
  endtask

  task automatic mon_rd(input int a, output logic [31:0] d, output bit ok);
    to_slot(1);
    mon_req = 1; mon_addr = 7'(a);
    #0.5;
    ok = mon_gnt;
    @(negedge clk);
    mon_req = 0;
    ok = ok && rd_vld && rd_who == 2'd1;
    d = rd_data;
  endtask

  // phase < 4 waits for that slot before strobing
  task automatic host_acc(input int phase, input bit we, input int a, input int b,
                          input logic [7:0] wd, output logic [7:0] rd, output int waits);
    if (phase < 4) to_slot(phase); else @(negedge clk);
    host_stb = 1; host_we = we; host_addr = 7'(a); host_bsel = 2'(b); host_wdata = wd;
    @(negedge clk);
    host_stb = 0;
    waits = 0;
    while (!host_ready) begin waits++; @(negedge clk); end
    rd = host_rdata;
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  rb;
    int w;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 0;
    chk(host_ready == 1, "R9 ready", host_ready, 1);
    chk(rd_vld == 0, "R9 rd_vld", rd_vld, 0);
    chk(host_rdata == 0, "R9 host_rdata", host_rdata, 0);
    chk(cur_slot == 0, "R1 reset slot", cur_slot, 0);
    // R1: slot sequence
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk(cur_slot == 2'(i), "R1 slot step", cur_slot, i % 4);
    end
    // R10/R2: fill every word from the filter
    for (int a = 0; a < 128; a++) filt_wr(a, pat(a));
    // R10/R4: monitor readback
    for (int a = 0; a < 128; a++) begin
      mon_rd(a, d, ok);
      chk(ok && d == pat(a), "R10/R4 monitor read", d, pat(a));
    end
    // R3: compute engine takes every idle slot
    to_slot(3);
    ce_req = 1; ce_we = 0; ce_addr = 7'h06;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #0.5;
      chk(ce_gnt == 1, "R3 ce idle slot", ce_gnt, 1);
      chk(rd_vld && rd_who == 2'd3 && rd_data == pat(6), "R4 ce read", rd_data, pat(6));
    end
    // R2/R3: everyone requests at once
    filt_req = 1; filt_we = 0; filt_addr = 7'h01; mon_req = 1; mon_addr = 7'h02;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #0.5;
      chk(filt_gnt == (cur_slot == 0), "R2 filt contention", filt_gnt, cur_slot == 0);
      chk(mon_gnt == (cur_slot == 1), "R2 mon contention", mon_gnt, cur_slot == 1);
      chk(ce_gnt == (cur_slot >= 2), "R3 ce contention", ce_gnt, cur_slot >= 2);
    end
    filt_req = 0; mon_req = 0; ce_req = 0;
    // R5/R6: host word writes started in each slot phase
    for (int s = 0; s < 4; s++) begin
      logic [31:0] hw;
      hw = 32'hC0DE_0000 | (32'(s) << 8) | 32'(s * 17);
      for (int b = 0; b < 3; b++) begin
        host_acc(4, 1, 8 + s, b, hw[b*8 +: 8], rb, w);
        chk(w == 0, "R5 low byte no wait", w, 0);
      end
      host_acc(s, 1, 8 + s, 3, hw[31:24], rb, w);
      chk(w == ((5 - s) % 4) + 1, "R6 commit waits", w, ((5 - s) % 4) + 1);
      mon_rd(8 + s, d, ok);
      chk(ok && d == hw, "R6 committed word", d, hw);
    end
    // R7/R8: host reads from each phase, memory changed behind the holding reg
    for (int s = 0; s < 4; s++) begin
      logic [31:0] hw;
      hw = 32'hC0DE_0000 | (32'(s) << 8) | 32'(s * 17);
      host_acc(s, 0, 8 + s, 0, 8'h00, rb, w);
      chk(w == ((5 - s) % 4) + 2, "R7 fetch waits", w, ((5 - s) % 4) + 2);
      chk(rb == hw[7:0], "R7 byte0", rb, hw[7:0]);
      filt_wr(8 + s, ~hw);
      for (int b = 1; b < 4; b++) begin
        host_acc(4, 0, 8 + s, b, 8'h00, rb, w);
        chk(w == 0 && rb == hw[b*8 +: 8], "R8 held byte", rb, hw[b*8 +: 8]);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule